// File: doc/BRIEF.md
# BIST Cycle Timer for a Scan Bridge

This block sits inside a JTAG scan bridge and times a built-in self-test that runs on a device behind a parked local scan port. The controlling tester scans a cycle count into a 32-bit down-counter through a data-register scan. It then enables counting by instruction and lets the bridge TAP idle. Each local test-clock pulse seen in Run-Test/Idle takes one off the count. When the count reaches zero, a done flag is raised and held.

The tester polls for completion by selecting an 8-bit mode register and scanning it. The done flag is the most significant bit of that register. The lower seven bits are ordinary writable mode bits. The counter must be disabled by instruction before the parked port is released to scan out the self-test result. The bridge TAP state machine, the instruction decoder and the self-test logic of the target device are outside this block. They reach it as state flags and instruction strobes, all synchronous to the bridge TCK.

Top module: `bist_cycle_timer`

## Requirements
- R1: An active-low `trst_n`, or `st_tlr` high at a TCK edge, clears the count to 0, turns counting off, clears done and returns `mode_reg` to 0x01.
- R2: While `op_cnt_sel` and `st_shift_dr` are high, each TCK edge shifts the count right by one bit, with `tdi` entering bit 31. `tdo` shows count bit 0, so values load and read LSB first. A scan that shifts a value back in reads it out unchanged.
- R3: A one-cycle `op_cnt_on` strobe turns counting on and `op_cnt_off` turns it off (off wins if both are high). While counting is off, local clock pulses leave the count unchanged.
- R4: While counting is on, `st_rti` high together with `lt_pulse` high at a TCK edge lowers a nonzero count by exactly one. A pulse outside Run-Test/Idle has no effect.
- R5: The count holds at zero. `done` rises at the edge where the count steps from 1 to 0, so it is set after exactly N pulses for a loaded value N and stays set.
- R6: `st_update_dr` with `op_cnt_sel` clears `done` when the loaded count is nonzero. Loading zero leaves `done` as it was.
- R7: Bit 7 of `mode_reg` always equals `done`.
- R8: With `op_mode_sel` high, the mode register is snapshotted while the bridge idles (or while not selected). During `st_shift_dr`, `tdo` presents the snapshot LSB first, so the 8th bit read is the done flag.
- R9: `st_update_dr` with `op_mode_sel` writes the first seven shifted bits into `mode_reg[6:0]`. The 8th shifted bit is ignored, and `mode_reg[7]` keeps showing `done`.
- R10: With neither `op_cnt_sel` nor `op_mode_sel` high, `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Bridge test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| st_tlr | input | 1 | Bridge TAP in Test-Logic-Reset |
| st_rti | input | 1 | Bridge TAP in Run-Test/Idle |
| st_shift_dr | input | 1 | Bridge TAP in Shift-DR |
| st_update_dr | input | 1 | Bridge TAP in Update-DR |
| op_cnt_on | input | 1 | Counter-enable instruction strobe |
| op_cnt_off | input | 1 | Counter-disable instruction strobe |
| op_cnt_sel | input | 1 | Counter register selected as data register |
| op_mode_sel | input | 1 | Mode register selected as data register |
| tdi | input | 1 | Bridge serial data in |
| lt_pulse | input | 1 | One local test-clock pulse, sampled on TCK |
| tdo | output | 1 | Serial data out of the selected register |
| done | output | 1 | Terminal count reached |
| mode_reg | output | 8 | Mode register, bit 7 is the done flag |

## Verification
On every cycle, the assertions check that Test-Logic-Reset clears the timer and that the count never moves while counting is off and no scan is active. They also check that each qualified pulse lowers the count by exactly one, that zero holds, that done only rises at zero, and that the mode register mirrors done. The bench scenarios show what a property cannot. These are the exact pulse on which done rises for a sweep of loads and pulse spacings, LSB-first scan round trips, the effect of loading zero versus a nonzero value, and the masking of the written top mode bit.

// File: rtl/bct_pkg.sv
package bct_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_CNT  = 2'd1,
      SRC_MODE = 2'd2
   } tdo_src_e;

   function automatic tdo_src_e pick_src(input logic cnt_sel, input logic mode_sel);
      if (cnt_sel)       return SRC_CNT;
      else if (mode_sel) return SRC_MODE;
      else               return SRC_NONE;
   endfunction
endpackage

// File: rtl/bct_cycle_counter.sv
module bct_cycle_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift_en,
   input  logic             upd_en,
   input  logic             tdi,
   input  logic             run_ok,
   input  logic             tick,
   input  logic             en_set,
   input  logic             en_clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             en_q,
   output logic             done_q,
   output logic             ser_out
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   if (CNT_W < 2) begin : g_bad_width
      $error("bct_cycle_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] shifted;
   logic             nonzero;
   logic             dec;

   for (genvar i = 0; i < CNT_W; i++) begin : g_shift
      if (i == CNT_W - 1) begin : g_top
         assign shifted[i] = tdi;
      end else begin : g_mid
         assign shifted[i] = cnt_q[i+1];
      end
   end

   assign nonzero = (cnt_q != ZERO);
   assign dec     = en_q && run_ok && tick && nonzero && !shift_en;
   assign ser_out = cnt_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= ZERO;
         en_q   <= 1'b0;
         done_q <= 1'b0;
      end else if (clr) begin
         cnt_q  <= ZERO;
         en_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (en_clr)      en_q <= 1'b0;
         else if (en_set) en_q <= 1'b1;

         if (shift_en) cnt_q <= shifted;
         else if (dec) cnt_q <= cnt_q - ONE;

         if (upd_en && nonzero)         done_q <= 1'b0;
         else if (dec && cnt_q == ONE)  done_q <= 1'b1;
      end
   end
endmodule

// File: rtl/bct_mode_reg.sv
module bct_mode_reg #(
   parameter int              MODE_W   = 8,
   parameter logic [MODE_W-1:0] MODE_RST = 'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              sel,
   input  logic              shift,
   input  logic              idle,
   input  logic              upd,
   input  logic              tdi,
   input  logic              done,
   output logic [MODE_W-1:0] mode_o,
   output logic              ser_out
);
   localparam int STORE_W  = MODE_W - 1;
   localparam int DONE_POS = MODE_W - 1;

   if (MODE_W < 2) begin : g_bad_width
      $error("bct_mode_reg: MODE_W must be at least 2");
   end
   if (MODE_RST[DONE_POS] != 1'b0) begin : g_bad_rst
      $error("bct_mode_reg: reset value must leave the done bit clear");
   end

   logic [STORE_W-1:0] store_q;
   logic [MODE_W-1:0]  snap_q;
   logic [MODE_W-1:0]  par;

   for (genvar i = 0; i < MODE_W; i++) begin : g_par
      if (i == DONE_POS) begin : g_status
         assign par[i] = done;
      end else begin : g_plain
         assign par[i] = store_q[i];
      end
   end

   assign mode_o  = par;
   assign ser_out = snap_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= MODE_RST[STORE_W-1:0];
         snap_q  <= MODE_RST;
      end else if (clr) begin
         store_q <= MODE_RST[STORE_W-1:0];
         snap_q  <= MODE_RST;
      end else begin
         if (sel && shift)        snap_q <= {tdi, snap_q[MODE_W-1:1]};
         else if (!sel || idle)   snap_q <= par;

         if (sel && upd && !shift) store_q <= snap_q[STORE_W-1:0];
      end
   end
endmodule

// File: rtl/bct_tdo_sel.sv
module bct_tdo_sel
   import bct_pkg::*;
(
   input  logic cnt_sel,
   input  logic mode_sel,
   input  logic cnt_bit,
   input  logic mode_bit,
   output logic tdo
);
   tdo_src_e src;

   always_comb begin
      src = pick_src(cnt_sel, mode_sel);
      unique case (src)
         SRC_CNT:  tdo = cnt_bit;
         SRC_MODE: tdo = mode_bit;
         default:  tdo = 1'b0;
      endcase
   end
endmodule

// File: rtl/bist_cycle_timer.sv
module bist_cycle_timer #(
   parameter int                CNT_W    = 32,
   parameter int                MODE_W   = 8,
   parameter logic [MODE_W-1:0] MODE_RST = 'h01
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              st_tlr,
   input  logic              st_rti,
   input  logic              st_shift_dr,
   input  logic              st_update_dr,
   input  logic              op_cnt_on,
   input  logic              op_cnt_off,
   input  logic              op_cnt_sel,
   input  logic              op_mode_sel,
   input  logic              tdi,
   input  logic              lt_pulse,
   output logic              tdo,
   output logic              done,
   output logic [MODE_W-1:0] mode_reg
);
   logic [CNT_W-1:0] cnt_q;
   logic             en_q;
   logic             cnt_bit;
   logic             mode_bit;
   logic             mode_sel_eff;

   assign mode_sel_eff = op_mode_sel && !op_cnt_sel;

   bct_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (tck),
      .rst_n    (trst_n),
      .clr      (st_tlr),
      .shift_en (op_cnt_sel && st_shift_dr),
      .upd_en   (op_cnt_sel && st_update_dr),
      .tdi      (tdi),
      .run_ok   (st_rti),
      .tick     (lt_pulse),
      .en_set   (op_cnt_on),
      .en_clr   (op_cnt_off),
      .cnt_q    (cnt_q),
      .en_q     (en_q),
      .done_q   (done),
      .ser_out  (cnt_bit)
   );

   bct_mode_reg #(.MODE_W(MODE_W), .MODE_RST(MODE_RST)) u_mode (
      .clk     (tck),
      .rst_n   (trst_n),
      .clr     (st_tlr),
      .sel     (mode_sel_eff),
      .shift   (st_shift_dr),
      .idle    (st_rti),
      .upd     (st_update_dr),
      .tdi     (tdi),
      .done    (done),
      .mode_o  (mode_reg),
      .ser_out (mode_bit)
   );

   bct_tdo_sel u_tdo (
      .cnt_sel  (op_cnt_sel),
      .mode_sel (op_mode_sel),
      .cnt_bit  (cnt_bit),
      .mode_bit (mode_bit),
      .tdo      (tdo)
   );
endmodule

// File: rtl/bct_checker.sv
module bct_checker #(
   parameter int                CNT_W    = 32,
   parameter int                MODE_W   = 8,
   parameter logic [MODE_W-1:0] MODE_RST = 'h01
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tlr,
   input logic              rti,
   input logic              shift,
   input logic              cnt_sel,
   input logic              pulse,
   input logic              en,
   input logic [CNT_W-1:0]  cnt,
   input logic              done,
   input logic [MODE_W-1:0] mode
);
   logic scan_cnt;
   assign scan_cnt = cnt_sel && shift;

   // R1
   a_r1_tlr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      tlr |=> (cnt == '0 && !en && !done && mode == MODE_RST));

   // R3
   a_r3_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !scan_cnt && !tlr) |=> $stable(cnt));

   // R4
   a_r4_step_of_one: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rti && pulse && cnt != '0 && !scan_cnt && !tlr) |=> (cnt == $past(cnt) - CNT_W'(1)));

   // R5
   a_r5_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !scan_cnt && !tlr) |=> (cnt == '0));

   // R5
   a_r5_done_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (cnt == '0));

   // R7
   a_r7_mode_mirrors_done: assert property (@(posedge clk) disable iff (!rst_n)
      mode[MODE_W-1] == done);
endmodule

bind bist_cycle_timer bct_checker #(.CNT_W(CNT_W), .MODE_W(MODE_W), .MODE_RST(MODE_RST)) u_chk (
   .clk     (tck),
   .rst_n   (trst_n),
   .tlr     (st_tlr),
   .rti     (st_rti),
   .shift   (st_shift_dr),
   .cnt_sel (op_cnt_sel),
   .pulse   (lt_pulse),
   .en      (en_q),
   .cnt     (cnt_q),
   .done    (done),
   .mode    (mode_reg)
);

// File: tb/sim_bist_cycle_timer.sv
`timescale 1ns/1ps
module sim_bist_cycle_timer;
   logic clk = 1'b0;
   logic trst_n = 1'b0;
   logic st_tlr = 0, st_rti = 0, st_shift_dr = 0, st_update_dr = 0;
   logic op_cnt_on = 0, op_cnt_off = 0, op_cnt_sel = 0, op_mode_sel = 0;
   logic tdi = 0, lt_pulse = 0;
   logic tdo, done;
   logic [7:0] mode_reg;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   bist_cycle_timer u0 (
      .tck(clk), .trst_n(trst_n), .st_tlr(st_tlr), .st_rti(st_rti),
      .st_shift_dr(st_shift_dr), .st_update_dr(st_update_dr),
      .op_cnt_on(op_cnt_on), .op_cnt_off(op_cnt_off), .op_cnt_sel(op_cnt_sel),
      .op_mode_sel(op_mode_sel), .tdi(tdi), .lt_pulse(lt_pulse),
      .tdo(tdo), .done(done), .mode_reg(mode_reg)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // scan the counter: shift v in, return what came out, then update
   task automatic scan_cnt(input logic [31:0] v, output logic [31:0] seen);
      op_cnt_sel = 1; op_mode_sel = 0; st_rti = 0; lt_pulse = 0;
      st_shift_dr = 1;
      for (int i = 0; i < 32; i++) begin
         tdi = v[i];
         #0.5 seen[i] = tdo;
         step();
      end
      st_shift_dr = 0; st_update_dr = 1; step();
      st_update_dr = 0; st_rti = 1; step();
   endtask

   task automatic scan_mode(input logic [7:0] v, output logic [7:0] seen);
      op_cnt_sel = 0; op_mode_sel = 1; st_rti = 1; lt_pulse = 0;
      step();
      st_rti = 0; st_shift_dr = 1;
      for (int i = 0; i < 8; i++) begin
         tdi = v[i];
         #0.5 seen[i] = tdo;
         step();
      end
      st_shift_dr = 0; st_update_dr = 1; step();
      st_update_dr = 0; st_rti = 1; step();
      op_mode_sel = 0;
   endtask

   task automatic strobe_on();  st_rti = 0; op_cnt_on = 1;  step(); op_cnt_on = 0;  endtask
   task automatic strobe_off(); st_rti = 0; op_cnt_off = 1; step(); op_cnt_off = 0; endtask

   task automatic pulses(input int n, input bit in_rti);
      st_rti = in_rti;
      for (int i = 0; i < n; i++) begin lt_pulse = 1; step(); end
      lt_pulse = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] got;
      logic [7:0]  mgot;
      step(); step();
      trst_n = 1; step();
      // R1 reset state
      chk(mode_reg == 8'h01, "R1 mode after reset", mode_reg, 8'h01);
      chk(done == 0, "R1 done after reset", done, 0);
      // R10 no register selected
      tdi = 1; #0.5;
      chk(tdo == 0, "R10 tdo idle", tdo, 0);
      step();

      // R2 load then non-destructive readback
      scan_cnt(32'hA5C3_0F17, got);
      chk(got == 32'h0, "R2 first scan out", got, 0);
      scan_cnt(32'hA5C3_0F17, got);
      chk(got == 32'hA5C3_0F17, "R2 round trip", got, 32'hA5C3_0F17);

      // R3 disabled: pulses ignored
      scan_cnt(32'd5, got);
      pulses(10, 1);
      scan_cnt(32'd5, got);
      chk(got == 32'd5, "R3 no count while off", got, 5);

      // R4 pulses outside idle ignored, inside idle count
      strobe_on();
      pulses(4, 0);
      scan_cnt(32'd5, got);
      chk(got == 32'd5, "R4 pulse outside idle", got, 5);
      pulses(3, 1);
      strobe_off();
      scan_cnt(32'd2, got);
      chk(got == 32'd2, "R4 three steps taken", got, 2);

      // R5 sweep: done after exactly N pulses, for several spacings
      for (int n = 1; n <= 8; n++) begin
         for (int g = 1; g <= 3; g++) begin
            bit bad;
            int p;
            bad = 0; p = 0;
            scan_cnt(n, got);
            if (done) bad = 1;
            strobe_on();
            st_rti = 1;
            for (int c = 0; c < 3 * n * g + 6; c++) begin
               lt_pulse = (c % g == 0);
               step();
               if (lt_pulse) p++;
               if (done != (p >= n)) bad = 1;
            end
            lt_pulse = 0;
            strobe_off();
            chk(!bad, $sformatf("R5 done timing n=%0d gap=%0d", n, g), done, 1);
            scan_cnt(32'd0, got);
            chk(got == 0, "R5 holds at zero", got, 0);
         end
      end

      // R7 mirror
      chk(mode_reg[7] == 1'b1 && done, "R7 bit7 is done", mode_reg, 8'h81);
      // R8 read mode; R9 write with top bit ignored
      scan_mode(8'h7E, mgot);
      chk(mgot == 8'h81, "R8 mode readout", mgot, 8'h81);
      chk(mode_reg == 8'hFE, "R9 mode write", mode_reg, 8'hFE);
      // R6 loading zero keeps done; nonzero clears it
      scan_cnt(32'd0, got);
      chk(done == 1, "R6 zero load keeps done", done, 1);
      scan_cnt(32'd9, got);
      chk(done == 0, "R6 nonzero load clears done", done, 0);
      chk(mode_reg == 8'h7E, "R7 mirror after clear", mode_reg, 8'h7E);
      scan_mode(8'hFF, mgot);
      chk(mgot == 8'h7E, "R8 readout with done low", mgot, 8'h7E);
      chk(mode_reg == 8'h7F, "R9 shifted bit7 ignored", mode_reg, 8'h7F);

      // R1 synchronous reset through Test-Logic-Reset
      strobe_on();
      st_rti = 0; st_tlr = 1; step(); st_tlr = 0;
      chk(mode_reg == 8'h01, "R1 mode after tlr", mode_reg, 8'h01);
      scan_cnt(32'd0, got);
      chk(got == 0, "R1 count cleared", got, 0);
      scan_cnt(32'd2, got);
      pulses(5, 1);
      scan_cnt(32'd2, got);
      chk(got == 2, "R1 enable cleared", got, 2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule